// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Word Codec

This block protects a 32-bit memory word by giving each of its four bytes a separate 5-bit check field. A stored word is therefore 52 bits wide and made of four 13-bit lanes. The code in each lane corrects one flipped bit and detects two flipped bits. Because every byte has its own check field, a byte-sized write needs no read-modify-write of the rest of the word. A single word can also carry up to four corrected errors, as long as each one is in a different byte.

The write path takes new data, a byte-enable mask and the word currently stored at the target address. It returns the 52-bit word to store. Enabled lanes are re-encoded from the new data. Disabled lanes are copied through bit for bit.

The read path takes a stored 52-bit word and returns:
- the corrected 32-bit data;
- a per-byte correctable mask and a per-byte uncorrectable mask;
- two word-level summary flags.

Checking and correction are always active. There is no enable and no bypass. Both paths are combinational internally and have one register stage at the outputs. A result therefore appears on the clock edge after its inputs are presented.

Top module: `sbc_word_codec`

## Requirements
- R1: Lane k of a stored word occupies bits [13k+12:13k]. Within a lane, bits [7:0] hold the data byte, bits [11:8] hold four Hamming bits h0..h3, and bit 12 is an overall parity bit. The data bits 0..7 take the Hamming positions 3,5,6,7,9,10,11,12 in that order. Bit hb is the XOR of the data bits whose position has bit b set. Bit 12 makes the XOR of all 13 lane bits zero.
- R2: On the write path, a lane whose byte enable is 1 is set to the encoding of the new data byte. A lane whose byte enable is 0 equals the corresponding lane of the old stored word, unchanged.
- R3: A stored word whose lanes are all valid encodings returns its data unchanged, with both masks zero and both word flags low.
- R4: Any single flipped bit in a lane, data or check, returns the original data byte and sets only that lane's correctable bit. A flip in a check bit leaves the data byte as stored.
- R5: Any two flipped bits in one lane set that lane's uncorrectable bit and clear its correctable bit.
- R6: One flipped bit in each of the four lanes at once is fully corrected, and the correctable mask reads 4'hF.
- R7: The word correctable flag is the OR of the correctable mask, and the word uncorrectable flag is the OR of the uncorrectable mask. Lanes report independently of one another.
- R8: While reset is high on a clock edge, all outputs are zero after that edge. Otherwise every output reflects the inputs present at the preceding edge, with one cycle of latency.
- R9: For a lane flagged uncorrectable, the returned data byte is the stored data bits with no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_i | input | 32 | New data to write |
| wr_be_i | input | 4 | Byte enables, bit k selects lane k |
| wr_old_i | input | 52 | Word currently stored at the write address |
| wr_word_o | output | 52 | Word to store, registered |
| rd_word_i | input | 52 | Stored word read from memory |
| rd_data_o | output | 32 | Corrected data, registered |
| rd_corr_o | output | 4 | Per-lane correctable error mask |
| rd_uncorr_o | output | 4 | Per-lane uncorrectable error mask |
| rd_any_corr_o | output | 1 | Some lane had a correctable error |
| rd_any_uncorr_o | output | 1 | Some lane had an uncorrectable error |

## Verification
The assertions assume that the stored word fed to the read path is all zeros plus a few flipped bits whenever they reason about error flags. An all-zero lane is a valid codeword, so a lane with exactly one set bit must be flagged correctable and one with two set bits uncorrectable. The stimulus builds every read word by encoding known data and then flipping chosen bit positions. Each lane therefore never carries more than two flips, and the single-bit and double-bit cases remain unambiguous. The write-path property compares disabled lanes against the old word from one cycle earlier. It is used only where reset was low on that earlier edge.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int BYTE_W  = 8;
  localparam int HAM_W   = 4;
  localparam int CHK_W   = HAM_W + 1;
  localparam int LANE_W  = BYTE_W + CHK_W;
  localparam int MAX_POS = BYTE_W + HAM_W;

  // Hamming position of data bit idx: the idx-th non power of two from 1 up.
  function automatic logic [HAM_W-1:0] data_pos(input int idx);
    int cnt;
    logic [HAM_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 1; p <= MAX_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = HAM_W'(p);
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/sbc_byte_enc.sv
module sbc_byte_enc
  import sbc_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o,
  output logic              par_o
);
  // Hamming bits are the XOR of the positions of all set data bits.
  always_comb begin
    ham_o = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ham_o = ham_o ^ (data_pos(i) & {HAM_W{data_i[i]}});
    end
    par_o = (^data_i) ^ (^ham_o);
  end
endmodule

// File: rtl/sbc_byte_dec.sv
module sbc_byte_dec
  import sbc_pkg::*;
(
  input  logic [LANE_W-1:0] lane_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  logic [BYTE_W-1:0] st_data;
  logic [HAM_W-1:0]  st_ham;
  logic              st_par;
  logic [HAM_W-1:0]  re_ham;
  logic              re_par;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              in_range;

  assign st_data = lane_i[BYTE_W-1:0];
  assign st_ham  = lane_i[BYTE_W +: HAM_W];
  assign st_par  = lane_i[LANE_W-1];

  sbc_byte_enc u_reenc (
    .data_i (st_data),
    .ham_o  (re_ham),
    .par_o  (re_par)
  );

  // odd equals the XOR of all stored lane bits.
  assign syn      = re_ham ^ st_ham;
  assign odd      = re_par ^ (^syn) ^ st_par;
  assign in_range = (syn <= HAM_W'(MAX_POS));
  assign corr_o   = odd & in_range;
  assign uncorr_o = (~odd & (syn != '0)) | (odd & ~in_range);

  always_comb begin
    data_o = st_data;
    for (int i = 0; i < BYTE_W; i++) begin
      if (corr_o && (syn == data_pos(i))) data_o[i] = ~st_data[i];
    end
  end
endmodule

// File: rtl/sbc_word_codec.sv
module sbc_word_codec
  import sbc_pkg::*;
#(
  parameter  int LANES  = 4,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [WORD_W-1:0] wr_old_i,
  output logic [WORD_W-1:0] wr_word_o,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LANES-1:0]  rd_corr_o,
  output logic [LANES-1:0]  rd_uncorr_o,
  output logic              rd_any_corr_o,
  output logic              rd_any_uncorr_o
);
  logic [WORD_W-1:0] wr_word_c;
  logic [DATA_W-1:0] rd_data_c;
  logic [LANES-1:0]  corr_c;
  logic [LANES-1:0]  uncorr_c;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [HAM_W-1:0] ham;
    logic             par;

    sbc_byte_enc u_enc (
      .data_i (wr_data_i[k*BYTE_W +: BYTE_W]),
      .ham_o  (ham),
      .par_o  (par)
    );

    assign wr_word_c[k*LANE_W +: LANE_W] = wr_be_i[k]
      ? {par, ham, wr_data_i[k*BYTE_W +: BYTE_W]}
      : wr_old_i[k*LANE_W +: LANE_W];

    sbc_byte_dec u_dec (
      .lane_i   (rd_word_i[k*LANE_W +: LANE_W]),
      .data_o   (rd_data_c[k*BYTE_W +: BYTE_W]),
      .corr_o   (corr_c[k]),
      .uncorr_o (uncorr_c[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_word_o       <= '0;
      rd_data_o       <= '0;
      rd_corr_o       <= '0;
      rd_uncorr_o     <= '0;
      rd_any_corr_o   <= 1'b0;
      rd_any_uncorr_o <= 1'b0;
    end else begin
      wr_word_o       <= wr_word_c;
      rd_data_o       <= rd_data_c;
      rd_corr_o       <= corr_c;
      rd_uncorr_o     <= uncorr_c;
      rd_any_corr_o   <= |corr_c;
      rd_any_uncorr_o <= |uncorr_c;
    end
  end
endmodule

// File: rtl/sbc_word_codec_checker.sv
module sbc_word_codec_checker
  import sbc_pkg::*;
#(
  parameter  int LANES  = 4,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [LANES-1:0]  wr_be_i,
  input logic [WORD_W-1:0] wr_old_i,
  input logic [WORD_W-1:0] wr_word_o,
  input logic [WORD_W-1:0] rd_word_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [LANES-1:0]  rd_corr_o,
  input logic [LANES-1:0]  rd_uncorr_o,
  input logic              rd_any_corr_o,
  input logic              rd_any_uncorr_o
);
  logic rst_seen = 1'b0;
  logic past_ok  = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    past_ok  <= !rst;
  end

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst_seen |-> (wr_word_o == '0 && rd_data_o == '0 && rd_corr_o == '0 &&
                  rd_uncorr_o == '0 && !rd_any_corr_o && !rd_any_uncorr_o));

  assert_masks_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_corr_o & rd_uncorr_o) == '0);

  assert_word_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_any_corr_o == (|rd_corr_o)) && (rd_any_uncorr_o == (|rd_uncorr_o)));

  assert_clean_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rd_word_i) == '0) |->
      (rd_data_o == '0 && rd_corr_o == '0 && rd_uncorr_o == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    assert_be_keep_R2: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(wr_be_i[k])) |->
        wr_word_o[k*LANE_W +: LANE_W] == $past(wr_old_i[k*LANE_W +: LANE_W]));

    assert_single_fixed_R4: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $countones($past(rd_word_i[k*LANE_W +: LANE_W])) == 1) |->
        (rd_corr_o[k] && !rd_uncorr_o[k] && rd_data_o[k*BYTE_W +: BYTE_W] == '0));

    assert_double_flag_R5: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $countones($past(rd_word_i[k*LANE_W +: LANE_W])) == 2) |->
        (rd_uncorr_o[k] && !rd_corr_o[k]));
  end
endmodule

bind sbc_word_codec sbc_word_codec_checker #(.LANES(LANES)) u_checker (
  .clk             (clk),
  .rst             (rst),
  .wr_be_i         (wr_be_i),
  .wr_old_i        (wr_old_i),
  .wr_word_o       (wr_word_o),
  .rd_word_i       (rd_word_i),
  .rd_data_o       (rd_data_o),
  .rd_corr_o       (rd_corr_o),
  .rd_uncorr_o     (rd_uncorr_o),
  .rd_any_corr_o   (rd_any_corr_o),
  .rd_any_uncorr_o (rd_any_uncorr_o)
);

// File: tb/test_sbc_word_codec.sv
module test_sbc_word_codec;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [51:0] wr_old = '0;
  logic [51:0] wr_word;
  logic [51:0] rd_word = '0;
  logic [31:0] rd_data;
  logic [3:0]  rd_corr;
  logic [3:0]  rd_uncorr;
  logic        any_corr;
  logic        any_uncorr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sbc_word_codec i_sbc_word_codec (
    .clk             (clk),
    .rst             (rst),
    .wr_data_i       (wr_data),
    .wr_be_i         (wr_be),
    .wr_old_i        (wr_old),
    .wr_word_o       (wr_word),
    .rd_word_i       (rd_word),
    .rd_data_o       (rd_data),
    .rd_corr_o       (rd_corr),
    .rd_uncorr_o     (rd_uncorr),
    .rd_any_corr_o   (any_corr),
    .rd_any_uncorr_o (any_uncorr)
  );

  // Lane encoding from R1: Hamming bits are the XOR of the data positions.
  function automatic logic [12:0] ref_lane(input logic [7:0] d);
    logic [3:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p <= 12; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) h = h ^ 4'(p);
        k++;
      end
    end
    return {^{d, h}, h, d};
  endfunction

  function automatic logic [51:0] ref_word(input logic [31:0] d);
    logic [51:0] w;
    for (int k = 0; k < 4; k++) w[13*k +: 13] = ref_lane(d[8*k +: 8]);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_expect(input string tag, input logic [51:0] w, input logic [31:0] ed,
                           input logic [3:0] ec, input logic [3:0] eu);
    rd_word = w;
    step();
    chk({tag, " data"}, 64'(rd_data), 64'(ed));
    chk({tag, " corr"}, 64'(rd_corr), 64'(ec));
    chk({tag, " uncorr"}, 64'(rd_uncorr), 64'(eu));
    chk({"R7 ", tag, " any_corr"}, 64'(any_corr), 64'(|ec));
    chk({"R7 ", tag, " any_uncorr"}, 64'(any_uncorr), 64'(|eu));
  endtask

  task automatic reset_check(input string tag);
    @(negedge clk);
    rst = 1'b1;
    wr_data = 32'hdead_beef;
    wr_be = 4'hf;
    wr_old = 52'h1;
    rd_word = 52'h3;
    repeat (2) step();
    chk({"R8 ", tag, " wr_word"}, 64'(wr_word), 64'h0);
    chk({"R8 ", tag, " rd_data"}, 64'(rd_data), 64'h0);
    chk({"R8 ", tag, " flags"}, 64'({rd_corr, rd_uncorr, any_corr, any_uncorr}), 64'h0);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [51:0] w;
    logic [51:0] e;
    logic [31:0] ed;
    reset_check("initial");

    // R1: encoding of every byte value in each lane
    for (int v = 0; v < 256; v++) begin
      d = {8'(v + 37), ~8'(v), 8'(v) ^ 8'h5a, 8'(v)};
      wr_data = d;
      wr_be = 4'hf;
      wr_old = 52'({$urandom(), $urandom()});
      step();
      chk("R1 encode", 64'(wr_word), 64'(ref_word(d)));
    end

    // R2: byte enables select encode or pass-through per lane
    for (int be = 0; be < 16; be++) begin
      for (int t = 0; t < 8; t++) begin
        d = $urandom();
        w = 52'({$urandom(), $urandom()});
        wr_data = d;
        wr_be = 4'(be);
        wr_old = w;
        e = ref_word(d);
        for (int k = 0; k < 4; k++) if (!be[k]) e[13*k +: 13] = w[13*k +: 13];
        step();
        chk("R2 byte enable", 64'(wr_word), 64'(e));
      end
    end

    // R3: clean words
    for (int v = 0; v < 256; v++) begin
      d = {8'(v * 3), 8'(v) ^ 8'hc3, ~8'(v), 8'(v)};
      rd_expect("R3 clean", ref_word(d), d, 4'h0, 4'h0);
    end

    // R4: every single-bit flip in every lane
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 13; p++) begin
        for (int t = 0; t < 16; t++) begin
          d = $urandom();
          w = ref_word(d);
          w[13*k + p] = ~w[13*k + p];
          rd_expect("R4 single", w, d, 4'(1 << k), 4'h0);
        end
      end
    end

    // R5 and R9: every double-bit flip in every lane
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 13; p++) begin
        for (int q = p + 1; q < 13; q++) begin
          for (int t = 0; t < 4; t++) begin
            d = $urandom();
            w = ref_word(d);
            w[13*k + p] = ~w[13*k + p];
            w[13*k + q] = ~w[13*k + q];
            ed = d;
            ed[8*k +: 8] = w[13*k +: 8];
            rd_expect("R5 R9 double", w, ed, 4'h0, 4'(1 << k));
          end
        end
      end
    end

    // R6: one flip in each lane at once
    for (int t = 0; t < 128; t++) begin
      d = $urandom();
      w = ref_word(d);
      for (int k = 0; k < 4; k++) begin
        int p;
        p = int'($urandom() % 13);
        w[13*k + p] = ~w[13*k + p];
      end
      rd_expect("R6 four singles", w, d, 4'hf, 4'h0);
    end

    // R7: mixed lanes, one double lane and single flips elsewhere
    for (int t = 0; t < 64; t++) begin
      int dk;
      logic [3:0] sm;
      dk = t % 4;
      sm = 4'($urandom()) & ~4'(1 << dk);
      d = $urandom();
      w = ref_word(d);
      w[13*dk + 0] = ~w[13*dk + 0];
      w[13*dk + 12] = ~w[13*dk + 12];
      ed = d;
      ed[8*dk +: 8] = w[13*dk +: 8];
      for (int k = 0; k < 4; k++) if (sm[k]) w[13*k + 5] = ~w[13*k + 5];
      rd_expect("R7 mixed", w, ed, sm, 4'(1 << dk));
    end

    reset_check("mid-run");
    rd_expect("R3 after reset", ref_word(32'h0123_4567), 32'h0123_4567, 4'h0, 4'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule